// File: doc/BRIEF.md
# Home directory controller for MSI coherence

This block sits at the memory side of a two-level coherent memory system. For every line it owns, it keeps one MSI state per child cache and one wait flag per child. The wait flag shows that a downgrade request has gone to that child and no answer has come back yet. It also holds the backing data for every line. Children send it upgrade requests (asking for S or M on a line) and downgrade responses (telling it a new, lower state, with data where the line was modified). It answers with grants, carrying line data when the child held nothing. When another child holds the line in a state that conflicts with a request, it sends that child a downgrade request instead.

Only one action happens per clock: accept one response, grant one request, send one downgrade request, or do nothing. Responses always go first. Among children that present the same kind of message in the same cycle, a rotating pick decides which is served. Every outgoing message leaves on one shared output register, one cycle after the decision. The output has no back-pressure.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, every child's state for every line is I (code 0), every wait flag is clear, all backing data reads as zero, and no output message or accept strobe is asserted.
- R2: A request from child c for line a asking for state y (S = 1, M = 2) is granted when two things hold: c's wait flag for a is clear, and every other child's state for a is compatible with y. Only the pairs (M,M), (M,S) and (S,M) are incompatible. The grant pulses `req_ready[c]`, records y for c, and the next cycle presents `out_valid=1`, `out_dgrade=0`, `out_child=c`, `out_addr=a`, `out_state=y`.
- R3: A grant carries the backing data with `out_has_data=1` only when c's recorded state was I before the grant. Otherwise `out_has_data=0` and `out_data=0`.
- R4: When a request cannot be granted, the controller picks the lowest-numbered other child that is incompatible and whose wait flag is clear. It sets that child's wait flag and, the next cycle, sends it a downgrade request (`out_dgrade=1`). The target state is I (0) for an M request and S (1) for an S request. The request is not accepted.
- R5: When the requester's own wait flag is set, or every incompatible child is already being waited on, and no downgrade can be sent, nothing is accepted and no message is sent. The request stays pending.
- R6: A downgrade response from child c for line a with state s pulses `rsp_ready[c]`. It writes the carried data to line a only when c was recorded in M, then records s for c and clears c's wait flag.
- R7: When any response is valid, no request is accepted in that cycle.
- R8: Responses and requests each use their own rotating pick. The search starts at the child after the one last served of that kind, and starts at child 0 after reset.
- R9: For every line, at most one child is recorded in M.
- R10: At most one accept strobe is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCHILD | Upgrade request present, per child |
| req_addr | input | NCHILD x AW | Requested line, per child |
| req_want | input | NCHILD x 2 | Requested state (1 = S, 2 = M), per child |
| req_ready | output | NCHILD | Request accepted (granted) this cycle |
| rsp_valid | input | NCHILD | Downgrade response present, per child |
| rsp_addr | input | NCHILD x AW | Line of the response, per child |
| rsp_state | input | NCHILD x 2 | New child state (0 = I, 1 = S) |
| rsp_data | input | NCHILD x DW | Line data returned by the child |
| rsp_ready | output | NCHILD | Response consumed this cycle |
| out_valid | output | 1 | Outgoing message valid |
| out_dgrade | output | 1 | 1 = downgrade request, 0 = grant |
| out_child | output | CW | Destination child |
| out_addr | output | AW | Line of the message |
| out_state | output | 2 | Granted state or downgrade target |
| out_has_data | output | 1 | Message carries line data |
| out_data | output | DW | Line data (zero when none) |

## Verification
The checker watches several rules on every cycle: the single-owner rule for every line, the priority of responses over requests, that at most one strobe is accepted, that each grant is recorded in the directory, and that each downgrade request leaves its wait flag set. Other behaviour shows only in the bench's scenarios, where a behavioural model predicts every strobe and message. That covers which child gets the downgrade, when data goes with a grant, write-back of modified data, stalls while responses are pending, and the rotating order.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } msi_t;

    // Two holders may share a line unless one of them has write ownership
    // and the other holds anything but I.
    function automatic logic coh_compat(msi_t held, msi_t want);
        logic bad;
        bad = (held == ST_M && want != ST_I) || (held == ST_S && want == ST_M);
        return !bad;
    endfunction

    // State a conflicting holder must drop to for a given request.
    function automatic msi_t coh_dg_target(msi_t want);
        return (want == ST_M) ? ST_I : ST_S;
    endfunction

endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 adv,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last_q;

    // Scan from far to near so the nearest candidate after last_q wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N; k >= 1; k--) begin
            if (req[(int'(last_q) + k) % N]) begin
                any = 1'b1;
                idx = IW'((int'(last_q) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (adv && any) begin
            last_q <= idx;
        end
    end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_pkg::*;
#(
    parameter int NCHILD = 4,
    parameter int NLINE  = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we_st,
    input  logic                                we_wt,
    input  logic [$clog2(NCHILD)-1:0]           child,
    input  logic [$clog2(NLINE)-1:0]            addr,
    input  msi_t                                st_val,
    input  logic                                wt_val,
    output msi_t [NLINE-1:0][NCHILD-1:0]        st_all,
    output logic [NLINE-1:0][NCHILD-1:0]        wt_all
);
    msi_t [NLINE-1:0][NCHILD-1:0] st_q;
    logic [NLINE-1:0][NCHILD-1:0] wt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NLINE; l++) begin
                for (int c = 0; c < NCHILD; c++) begin
                    st_q[l][c] <= ST_I;
                    wt_q[l][c] <= 1'b0;
                end
            end
        end else begin
            if (we_st) st_q[addr][child] <= st_val;
            if (we_wt) wt_q[addr][child] <= wt_val;
        end
    end

    assign st_all = st_q;
    assign wt_all = wt_q;
endmodule

// File: rtl/coh_line_mem.sv
module coh_line_mem #(
    parameter int NLINE = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(NLINE)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(NLINE)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] line_q [NLINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NLINE; l++) line_q[l] <= '0;
        end else if (we) begin
            line_q[waddr] <= wdata;
        end
    end

    assign rdata = line_q[raddr];
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_pkg::*;
#(
    parameter int NCHILD = 4,
    parameter int NLINE  = 16,
    parameter int DW     = 32,
    localparam int AW    = $clog2(NLINE),
    localparam int CW    = $clog2(NCHILD)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCHILD-1:0]            req_valid,
    input  logic [NCHILD-1:0][AW-1:0]    req_addr,
    input  logic [NCHILD-1:0][1:0]       req_want,
    output logic [NCHILD-1:0]            req_ready,
    input  logic [NCHILD-1:0]            rsp_valid,
    input  logic [NCHILD-1:0][AW-1:0]    rsp_addr,
    input  logic [NCHILD-1:0][1:0]       rsp_state,
    input  logic [NCHILD-1:0][DW-1:0]    rsp_data,
    output logic [NCHILD-1:0]            rsp_ready,
    output logic                         out_valid,
    output logic                         out_dgrade,
    output logic [CW-1:0]                out_child,
    output logic [AW-1:0]                out_addr,
    output logic [1:0]                   out_state,
    output logic                         out_has_data,
    output logic [DW-1:0]                out_data
);
    typedef struct packed {
        logic          valid;
        logic          dgrade;
        logic [CW-1:0] child;
        logic [AW-1:0] addr;
        msi_t          state;
        logic          has_data;
        logic [DW-1:0] data;
    } out_msg_t;

    // Directory and data storage
    msi_t [NLINE-1:0][NCHILD-1:0] st_all;
    logic [NLINE-1:0][NCHILD-1:0] wt_all;
    logic          tw_st, tw_wt, tw_wtv;
    logic [CW-1:0] tw_child;
    logic [AW-1:0] tw_addr;
    msi_t          tw_stv;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    // Arbitration
    logic          rsp_any, req_any;
    logic [CW-1:0] rc, qc;

    coh_rr_arb #(.N(NCHILD)) u_rsp_arb (
        .clk(clk), .rst(rst), .req(rsp_valid), .adv(rsp_any),
        .any(rsp_any), .idx(rc)
    );

    coh_rr_arb #(.N(NCHILD)) u_req_arb (
        .clk(clk), .rst(rst), .req(req_valid), .adv(!rsp_any),
        .any(req_any), .idx(qc)
    );

    coh_dir_table #(.NCHILD(NCHILD), .NLINE(NLINE)) u_table (
        .clk(clk), .rst(rst), .we_st(tw_st), .we_wt(tw_wt),
        .child(tw_child), .addr(tw_addr), .st_val(tw_stv), .wt_val(tw_wtv),
        .st_all(st_all), .wt_all(wt_all)
    );

    logic [AW-1:0] qa, ra;
    msi_t          want;
    assign qa   = req_addr[qc];
    assign ra   = rsp_addr[rc];
    assign want = msi_t'(req_want[qc]);

    coh_line_mem #(.NLINE(NLINE), .DW(DW)) u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(qa), .rdata(mem_rdata)
    );

    // Conflict scan over the other children of the requested line
    logic          others_ok, dg_found;
    logic [CW-1:0] dg_idx;

    always_comb begin
        others_ok = 1'b1;
        dg_found  = 1'b0;
        dg_idx    = '0;
        for (int i = NCHILD - 1; i >= 0; i--) begin
            if (CW'(i) != qc && !coh_compat(st_all[qa][i], want)) begin
                others_ok = 1'b0;
                if (!wt_all[qa][i]) begin
                    dg_found = 1'b1;
                    dg_idx   = CW'(i);
                end
            end
        end
    end

    // Per-cycle decision: response, grant, downgrade or nothing
    out_msg_t nxt, msg_q;

    always_comb begin
        rsp_ready = '0;
        req_ready = '0;
        tw_st     = 1'b0;
        tw_wt     = 1'b0;
        tw_wtv    = 1'b0;
        tw_child  = '0;
        tw_addr   = '0;
        tw_stv    = ST_I;
        mem_we    = 1'b0;
        mem_waddr = ra;
        mem_wdata = rsp_data[rc];
        nxt       = '0;
        if (rsp_any) begin
            rsp_ready[rc] = 1'b1;
            tw_st    = 1'b1;
            tw_wt    = 1'b1;
            tw_wtv   = 1'b0;
            tw_child = rc;
            tw_addr  = ra;
            tw_stv   = msi_t'(rsp_state[rc]);
            mem_we   = (st_all[ra][rc] == ST_M);
        end else if (req_any) begin
            if (others_ok && !wt_all[qa][qc]) begin
                req_ready[qc] = 1'b1;
                tw_st        = 1'b1;
                tw_child     = qc;
                tw_addr      = qa;
                tw_stv       = want;
                nxt.valid    = 1'b1;
                nxt.child    = qc;
                nxt.addr     = qa;
                nxt.state    = want;
                nxt.has_data = (st_all[qa][qc] == ST_I);
                nxt.data     = (st_all[qa][qc] == ST_I) ? mem_rdata : '0;
            end else if (dg_found) begin
                tw_wt      = 1'b1;
                tw_wtv     = 1'b1;
                tw_child   = dg_idx;
                tw_addr    = qa;
                nxt.valid  = 1'b1;
                nxt.dgrade = 1'b1;
                nxt.child  = dg_idx;
                nxt.addr   = qa;
                nxt.state  = coh_dg_target(want);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) msg_q <= '0;
        else     msg_q <= nxt;
    end

    assign out_valid    = msg_q.valid;
    assign out_dgrade   = msg_q.dgrade;
    assign out_child    = msg_q.child;
    assign out_addr     = msg_q.addr;
    assign out_state    = msg_q.state;
    assign out_has_data = msg_q.has_data;
    assign out_data     = msg_q.data;
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk
    import coh_pkg::*;
#(
    parameter int NCHILD = 4,
    parameter int NLINE  = 16,
    localparam int AW    = $clog2(NLINE),
    localparam int CW    = $clog2(NCHILD)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NCHILD-1:0]            rsp_valid,
    input logic [NCHILD-1:0]            rsp_ready,
    input logic [NCHILD-1:0]            req_ready,
    input logic                         out_valid,
    input logic                         out_dgrade,
    input logic [CW-1:0]                out_child,
    input logic [AW-1:0]                out_addr,
    input logic [1:0]                   out_state,
    input msi_t [NLINE-1:0][NCHILD-1:0] st_all,
    input logic [NLINE-1:0][NCHILD-1:0] wt_all
);
    logic owner_ok;

    always_comb begin
        owner_ok = 1'b1;
        for (int l = 0; l < NLINE; l++) begin
            int cnt;
            cnt = 0;
            for (int c = 0; c < NCHILD; c++) begin
                if (st_all[l][c] == ST_M) cnt++;
            end
            if (cnt > 1) owner_ok = 1'b0;
        end
    end

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        owner_ok); // R9

    AST_RSP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|rsp_valid) |-> (req_ready == '0)); // R7

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_ready, req_ready})); // R10

    AST_GRANT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (|req_ready) |=> (out_valid && !out_dgrade)); // R2

    AST_GRANT_RECORDED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_dgrade) |-> (st_all[out_addr][out_child] == msi_t'(out_state))); // R2

    AST_DG_WAIT_SET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dgrade) |-> wt_all[out_addr][out_child]); // R4

    AST_DG_LOWER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dgrade) |-> (out_state != 2'd2)); // R4
endmodule

bind coh_dir_ctrl coh_dir_chk #(.NCHILD(NCHILD), .NLINE(NLINE)) u_chk (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .out_valid(out_valid), .out_dgrade(out_dgrade),
    .out_child(out_child), .out_addr(out_addr), .out_state(out_state),
    .st_all(st_all), .wt_all(wt_all)
);

// File: tb/coh_dir_ctrl_test.sv
`timescale 1ns/1ps
module coh_dir_ctrl_test;
    localparam int N  = 4;
    localparam int NL = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [N-1:0]          req_valid = '0;
    logic [N-1:0][3:0]     req_addr  = '0;
    logic [N-1:0][1:0]     req_want  = '0;
    logic [N-1:0]          req_ready;
    logic [N-1:0]          rsp_valid = '0;
    logic [N-1:0][3:0]     rsp_addr  = '0;
    logic [N-1:0][1:0]     rsp_state = '0;
    logic [N-1:0][DW-1:0]  rsp_data  = '0;
    logic [N-1:0]          rsp_ready;
    logic                  out_valid, out_dgrade, out_has_data;
    logic [1:0]            out_child;
    logic [3:0]            out_addr;
    logic [1:0]            out_state;
    logic [DW-1:0]         out_data;

    coh_dir_ctrl #(.NCHILD(N), .NLINE(NL), .DW(DW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_want(req_want), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_state(rsp_state), .rsp_data(rsp_data),
        .rsp_ready(rsp_ready),
        .out_valid(out_valid), .out_dgrade(out_dgrade), .out_child(out_child),
        .out_addr(out_addr), .out_state(out_state), .out_has_data(out_has_data),
        .out_data(out_data)
    );

    // Behavioural model: I=0, S=1, M=2; a pair conflicts when its codes sum above 2.
    int           m_st [N][NL];
    int           m_wt [N][NL];
    logic [DW-1:0] m_mem [NL];
    int           m_rp, m_qp;
    int           n_chk = 0, n_fail = 0;
    string        tag = "R1";
    bit           done = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < N; c++)
            for (int a = 0; a < NL; a++) begin
                m_st[c][a] = 0;
                m_wt[c][a] = 0;
            end
        for (int a = 0; a < NL; a++) m_mem[a] = '0;
        m_rp = N - 1;
        m_qp = N - 1;
    endtask

    // Called just after a falling edge with inputs settled.
    task automatic step();
        logic [N-1:0]  e_rsp, e_req;
        bit            e_v, e_dg, e_hd;
        int            e_ch, e_ad, e_st;
        logic [DW-1:0] e_dt;
        int rc, qc, a, w, tgt;
        bit blocked;
        e_rsp = '0; e_req = '0; e_v = 0; e_dg = 0; e_hd = 0;
        e_ch = 0; e_ad = 0; e_st = 0; e_dt = '0;
        rc = -1; qc = -1;
        for (int k = 1; k <= N; k++)
            if (rc < 0 && rsp_valid[(m_rp + k) % N]) rc = (m_rp + k) % N;
        if (rc >= 0) begin
            a = int'(rsp_addr[rc]);
            e_rsp[rc] = 1'b1;
            if (m_st[rc][a] == 2) m_mem[a] = rsp_data[rc];
            m_st[rc][a] = int'(rsp_state[rc]);
            m_wt[rc][a] = 0;
            m_rp = rc;
        end else begin
            for (int k = 1; k <= N; k++)
                if (qc < 0 && req_valid[(m_qp + k) % N]) qc = (m_qp + k) % N;
            if (qc >= 0) begin
                m_qp = qc;
                a = int'(req_addr[qc]);
                w = int'(req_want[qc]);
                blocked = (m_wt[qc][a] != 0);
                tgt = -1;
                for (int i = 0; i < N; i++)
                    if (i != qc && m_st[i][a] + w > 2) begin
                        blocked = 1;
                        if (tgt < 0 && m_wt[i][a] == 0) tgt = i;
                    end
                if (!blocked) begin
                    e_req[qc] = 1'b1;
                    e_v = 1; e_ch = qc; e_ad = a; e_st = w;
                    e_hd = (m_st[qc][a] == 0);
                    e_dt = e_hd ? m_mem[a] : '0;
                    m_st[qc][a] = w;
                end else if (tgt >= 0) begin
                    e_v = 1; e_dg = 1; e_ch = tgt; e_ad = a;
                    e_st = (w == 2) ? 0 : 1;
                    m_wt[tgt][a] = 1;
                end
            end
        end
        #1;
        chk(rsp_ready == e_rsp, "rsp_ready", rsp_ready, e_rsp);
        chk(req_ready == e_req, "req_ready", req_ready, e_req);
        @(negedge clk);
        chk(out_valid == e_v, "out_valid", out_valid, e_v);
        if (e_v) begin
            chk(out_dgrade == e_dg, "out_dgrade", out_dgrade, e_dg);
            chk(int'(out_child) == e_ch, "out_child", out_child, e_ch);
            chk(int'(out_addr) == e_ad, "out_addr", out_addr, e_ad);
            chk(int'(out_state) == e_st, "out_state", out_state, e_st);
            chk(out_has_data == e_hd, "out_has_data", out_has_data, e_hd);
            chk(out_data == e_dt, "out_data", out_data, e_dt);
        end
        req_valid = req_valid & ~e_req;
        rsp_valid = rsp_valid & ~e_rsp;
    endtask

    task automatic post_req(input int c, input int a, input int w);
        req_valid[c] = 1'b1;
        req_addr[c]  = 4'(a);
        req_want[c]  = 2'(w);
    endtask

    task automatic post_rsp(input int c, input int a, input int s, input logic [DW-1:0] d);
        rsp_valid[c] = 1'b1;
        rsp_addr[c]  = 4'(a);
        rsp_state[c] = 2'(s);
        rsp_data[c]  = d;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (req_valid == '0 && rsp_valid == '0) break;
            step();
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(out_valid == 1'b0, "out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        run(2);
        // R1 / R3: first grant of a fresh line carries zero data
        post_req(0, 3, 1);
        tag = "R3";
        drain(4);
        // R2: a second sharer is compatible
        tag = "R2";
        post_req(1, 3, 1);
        drain(4);
        // R4 then R5: M request against two sharers, stall while both pending
        tag = "R4";
        post_req(2, 3, 2);
        run(2);
        tag = "R5";
        run(2);
        // R6: responses of sharers carry no write-back
        tag = "R6";
        post_rsp(0, 3, 0, 32'hDEAD_0000);
        post_rsp(1, 3, 0, 32'hDEAD_0001);
        drain(6);
        // R6: write-back from the owner, then R3 data to the new sharer
        post_req(0, 3, 1);
        tag = "R4";
        run(1);
        tag = "R6";
        post_rsp(2, 3, 1, 32'hCAFE_F00D);
        drain(4);
        // R3: upgrade S to M carries no data
        tag = "R3";
        post_req(0, 3, 2);
        run(1);
        post_rsp(2, 3, 0, 32'h1111_2222);
        drain(4);
        // R5: requester whose own downgrade is outstanding stays blocked
        tag = "R5";
        post_req(1, 3, 1);
        run(1);
        post_req(0, 3, 1);
        run(3);
        tag = "R6";
        post_rsp(0, 3, 1, 32'h5A5A_A5A5);
        drain(6);
        // R7: response and request together
        tag = "R7";
        post_req(3, 7, 1);
        post_rsp(1, 3, 0, 32'h0);
        drain(4);
        // R8: rotating order among simultaneous requests and responses
        tag = "R8";
        post_req(0, 9, 1);
        post_req(1, 10, 2);
        post_req(2, 11, 1);
        post_req(3, 12, 2);
        drain(8);
        post_rsp(3, 12, 0, 32'h0000_0C0C);
        post_rsp(1, 10, 0, 32'h0000_0A0A);
        drain(4);
        post_req(2, 10, 1);
        post_req(0, 12, 1);
        drain(6);
        // R9 / R10: contention for M on one line from all children
        tag = "R9";
        post_req(0, 5, 2);
        post_req(1, 5, 2);
        post_req(2, 5, 2);
        run(6);
        post_rsp(0, 5, 0, 32'h0000_0505);
        run(4);
        tag = "R10";
        post_rsp(1, 5, 0, 32'h0);
        post_rsp(2, 5, 0, 32'h0);
        drain(10);
        run(2);
        done = 1;
        summary();
        $finish;
    end
endmodule